// File: doc/BRIEF.md
# PWM Time-Base Counter with Cascaded Prescaler

This block produces the time base shared by the two channels of a PWM unit. A control register selects one of four counting modes, a coarse prescaler stage that divides the system clock by a power of two, a fine stage that divides by an even number, and whether a new period value takes effect at once or waits. A second write port supplies the 16-bit period value, which holds the wanted number of ticks minus one.

On every prescaled tick the counter steps up, down or up-and-down between zero and the active period, or it holds in the frozen mode. The block outputs the counter value and the current count direction. It also outputs two single-cycle strobes that mark the counter arriving at zero and at the active period. Downstream compare and action logic uses these values to form the PWM waveforms.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter is 0, the direction flag is 1 (up), both strobes are 0, the mode is frozen (code 3), both divider selects are 0, loading is shadowed, and the active and shadow periods are 65535.
- R2: In mode code 0 (up), each tick advances the counter by one. On the tick after the counter reaches or exceeds the active period, it wraps to 0. The direction flag is 1.
- R3: In mode code 1 (down), each tick lowers the counter by one. On the tick after the counter reaches 0, it reloads the active period. The direction flag is 0.
- R4: In mode code 2 (up-down), the counter rises until it reaches the active period and then falls until it reaches 0. The direction flag changes on the tick that turns the counter around: it is 1 while rising and 0 while falling.
- R5: In mode code 3 (frozen), no tick is produced. The counter and direction flag hold and no strobe fires. Leaving this mode resumes counting from the held value.
- R6: The tick rate equals the clock divided by 2^n × k, where n is the 3-bit coarse select, and k is 2·m for a 3-bit fine select m, or 1 when m is 0. The prescaler restarts from phase 0 whenever the mode is frozen.
- R7: With the load bit at 0 (shadowed), a written period goes only to the shadow register. It becomes active on the tick that moves the counter to 0.
- R8: With the load bit at 1 (immediate), a written period becomes active on the next clock edge. The load bit in effect is the one stored before the write.
- R9: The zero strobe is high for one clock after a tick that moves the counter to 0. The period strobe is high for one clock after a tick that moves the counter to the active period. Neither strobe fires without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| ctl_we_i | input | 1 | Write strobe for the control register |
| ctl_mode_i | input | 2 | Mode: 0 up, 1 down, 2 up-down, 3 frozen |
| ctl_coarse_i | input | 3 | Coarse prescaler select n (divide by 2^n) |
| ctl_fine_i | input | 3 | Fine prescaler select m (divide by 2m, or 1 when 0) |
| ctl_imm_i | input | 1 | Period load: 0 shadowed, 1 immediate |
| per_we_i | input | 1 | Write strobe for the period value |
| per_data_i | input | 16 | Period value (ticks minus one) |
| cnt_o | output | 16 | Counter value |
| dir_up_o | output | 1 | Count direction, 1 while counting up |
| zero_evt_o | output | 1 | One-clock strobe on reaching zero |
| prd_evt_o | output | 1 | One-clock strobe on reaching the active period |

## Verification
The assertions check, on every clock, the single-step rules of the up and down modes, the hold and silence of the frozen mode, the direction reversal at the top in up-down mode, and the one-clock width of both strobes. The bench's scenarios are the only check of the timing details: the exact tick spacing for a given prescaler pair, the moment a shadowed period becomes active, the wrap when an immediate period drops below the counter, and the resume from a held value.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;
  typedef enum logic [1:0] {
    MODE_UP   = 2'd0,
    MODE_DOWN = 2'd1,
    MODE_UPDN = 2'd2,
    MODE_HOLD = 2'd3
  } tb_mode_e;

  typedef struct packed {
    tb_mode_e   mode;
    logic [2:0] coarse;
    logic [2:0] fine;
    logic       imm;
  } tb_ctl_t;
endpackage

// File: rtl/pwm_tb_prescaler.sv
module pwm_tb_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] coarse_i,
  input  logic [SEL_W-1:0] fine_i,
  output logic             tick_o
);
  localparam int C1_W = (1 << SEL_W) - 1;
  localparam int C2_W = SEL_W + 1;

  logic [C1_W-1:0] c1_q, c1_d, lim1;
  logic [C2_W-1:0] c2_q, c2_d, lim2;
  logic            t1;

  always_comb begin
    lim1   = {C1_W{1'b1}} >> (C1_W - int'(coarse_i));
    lim2   = (fine_i == '0) ? '0 : ({fine_i, 1'b0} - C2_W'(1));
    t1     = (c1_q >= lim1);
    tick_o = run_i && t1 && (c2_q >= lim2);
    if (!run_i) begin
      c1_d = '0;
      c2_d = '0;
    end else begin
      c1_d = t1 ? '0 : c1_q + C1_W'(1);
      if (tick_o)  c2_d = '0;
      else if (t1) c2_d = c2_q + C2_W'(1);
      else         c2_d = c2_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c1_q <= '0;
      c2_q <= '0;
    end else begin
      c1_q <= c1_d;
      c2_q <= c2_d;
    end
  end
endmodule

// File: rtl/pwm_tb_period.sv
module pwm_tb_period #(
  parameter int          CNT_W   = 16,
  parameter logic [15:0] PRD_RST = 16'hFFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             imm_i,
  input  logic             zero_ld_i,
  output logic [CNT_W-1:0] act_o
);
  logic [CNT_W-1:0] shd_q, shd_d, act_q, act_d;

  always_comb begin
    shd_d = we_i ? data_i : shd_q;
    if (we_i && imm_i) act_d = data_i;
    else if (zero_ld_i) act_d = shd_q;
    else                act_d = act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= CNT_W'(PRD_RST);
      act_q <= CNT_W'(PRD_RST);
    end else begin
      shd_q <= shd_d;
      act_q <= act_d;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  tb_mode_e         mode_i,
  input  logic [CNT_W-1:0] prd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             zero_evt_o,
  output logic             prd_evt_o,
  output logic             zero_ld_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d, zevt_q, pevt_q, zero_hit, prd_hit;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (tick_i) begin
      unique case (mode_i)
        MODE_UP: begin
          dir_d = 1'b1;
          cnt_d = (cnt_q >= prd_i) ? '0 : cnt_q + CNT_W'(1);
        end
        MODE_DOWN: begin
          dir_d = 1'b0;
          cnt_d = (cnt_q == '0) ? prd_i : cnt_q - CNT_W'(1);
        end
        MODE_UPDN: begin
          if (dir_q) begin
            if (cnt_q >= prd_i) begin
              dir_d = 1'b0;
              cnt_d = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end else begin
            if (cnt_q == '0) begin
              dir_d = 1'b1;
              cnt_d = (prd_i == '0) ? '0 : CNT_W'(1);
            end else begin
              cnt_d = cnt_q - CNT_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
    zero_hit = tick_i && (cnt_d == '0);
    prd_hit  = tick_i && (cnt_d == prd_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      dir_q  <= 1'b1;
      zevt_q <= 1'b0;
      pevt_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
      zevt_q <= zero_hit;
      pevt_q <= prd_hit;
    end
  end

  assign cnt_o      = cnt_q;
  assign dir_o      = dir_q;
  assign zero_evt_o = zevt_q;
  assign prd_evt_o  = pevt_q;
  assign zero_ld_o  = zero_hit;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int          CNT_W   = 16,
  parameter int          SEL_W   = 3,
  parameter logic [15:0] PRD_RST = 16'hFFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [1:0]       ctl_mode_i,
  input  logic [SEL_W-1:0] ctl_coarse_i,
  input  logic [SEL_W-1:0] ctl_fine_i,
  input  logic             ctl_imm_i,
  input  logic             per_we_i,
  input  logic [CNT_W-1:0] per_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_up_o,
  output logic             zero_evt_o,
  output logic             prd_evt_o
);
  logic [1:0]       mode_q, mode_d;
  logic [SEL_W-1:0] coarse_q, coarse_d, fine_q, fine_d;
  logic             imm_q, imm_d;
  logic             presc_tick, zero_ld, run;
  logic [CNT_W-1:0] prd_act;
  tb_mode_e         cur_mode;

  always_comb begin
    mode_d   = ctl_we_i ? ctl_mode_i   : mode_q;
    coarse_d = ctl_we_i ? ctl_coarse_i : coarse_q;
    fine_d   = ctl_we_i ? ctl_fine_i   : fine_q;
    imm_d    = ctl_we_i ? ctl_imm_i    : imm_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= 2'(MODE_HOLD);
      coarse_q <= '0;
      fine_q   <= '0;
      imm_q    <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      coarse_q <= coarse_d;
      fine_q   <= fine_d;
      imm_q    <= imm_d;
    end
  end

  assign cur_mode = tb_mode_e'(mode_q);
  assign run      = (cur_mode != MODE_HOLD);

  pwm_tb_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .coarse_i (coarse_q),
    .fine_i   (fine_q),
    .tick_o   (presc_tick)
  );

  pwm_tb_period #(.CNT_W(CNT_W), .PRD_RST(PRD_RST)) u_period (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (per_we_i),
    .data_i    (per_data_i),
    .imm_i     (imm_q),
    .zero_ld_i (zero_ld),
    .act_o     (prd_act)
  );

  pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (presc_tick),
    .mode_i     (cur_mode),
    .prd_i      (prd_act),
    .cnt_o      (cnt_o),
    .dir_o      (dir_up_o),
    .zero_evt_o (zero_evt_o),
    .prd_evt_o  (prd_evt_o),
    .zero_ld_o  (zero_ld)
  );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             tick_i,
  input logic [CNT_W-1:0] prd_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             dir_i,
  input logic             zevt_i,
  input logic             pevt_i
);
  // R2
  up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && tick_i && cnt_i < prd_i) |=> cnt_i == $past(cnt_i) + CNT_W'(1));

  // R3
  down_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && tick_i && cnt_i != '0) |=> cnt_i == $past(cnt_i) - CNT_W'(1));

  // R4
  updn_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && tick_i && dir_i && cnt_i >= prd_i && prd_i != '0) |=> !dir_i);

  // R5
  frozen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3) |=> ($stable(cnt_i) && $stable(dir_i) && !zevt_i && !pevt_i));

  // R9
  zero_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zevt_i && prd_i != '0) |=> !zevt_i);

  // R9
  prd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pevt_i && prd_i != '0) |=> !pevt_i);
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .mode_i (mode_q),
  .tick_i (presc_tick),
  .prd_i  (prd_act),
  .cnt_i  (cnt_o),
  .dir_i  (dir_up_o),
  .zevt_i (zero_evt_o),
  .pevt_i (prd_evt_o)
);

// File: tb/test_pwm_timebase.sv
module test_pwm_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [1:0]  ctl_mode = 2'd3;
  logic [2:0]  ctl_coarse = 3'd0;
  logic [2:0]  ctl_fine = 3'd0;
  logic        ctl_imm = 1'b0;
  logic        per_we = 1'b0;
  logic [15:0] per_data = 16'd0;
  logic [15:0] cnt;
  logic        dir_up, zevt, pevt;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string req = "R1";

  // behavioural reference state
  int m_mode, m_coarse, m_fine, m_imm, m_phase, m_cnt, m_dir, m_z, m_p, m_act, m_shd;

  always #2 clk = ~clk;

  pwm_timebase i_pwm_timebase (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(ctl_we), .ctl_mode_i(ctl_mode),
    .ctl_coarse_i(ctl_coarse), .ctl_fine_i(ctl_fine), .ctl_imm_i(ctl_imm),
    .per_we_i(per_we), .per_data_i(per_data), .cnt_o(cnt), .dir_up_o(dir_up),
    .zero_evt_o(zevt), .prd_evt_o(pevt)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 3; m_coarse = 0; m_fine = 0; m_imm = 0; m_phase = 0;
      m_cnt = 0; m_dir = 1; m_z = 0; m_p = 0; m_act = 65535; m_shd = 65535;
    end else begin
      int ratio, nxt, ndir, tick, ldz;
      ratio = (1 << m_coarse) * ((m_fine == 0) ? 1 : 2 * m_fine);
      if (m_mode == 3) begin tick = 0; m_phase = 0; end
      else begin
        tick = (m_phase == ratio - 1);
        m_phase = tick ? 0 : m_phase + 1;
      end
      nxt = m_cnt; ndir = m_dir;
      if (tick) begin
        case (m_mode)
          0: begin ndir = 1; nxt = (m_cnt >= m_act) ? 0 : m_cnt + 1; end
          1: begin ndir = 0; nxt = (m_cnt == 0) ? m_act : m_cnt - 1; end
          default: begin
            if (m_dir == 1) begin
              if (m_cnt >= m_act) begin ndir = 0; nxt = (m_cnt == 0) ? 0 : m_cnt - 1; end
              else nxt = m_cnt + 1;
            end else begin
              if (m_cnt == 0) begin ndir = 1; nxt = (m_act == 0) ? 0 : 1; end
              else nxt = m_cnt - 1;
            end
          end
        endcase
      end
      m_z = tick && nxt == 0;
      m_p = tick && nxt == m_act;
      ldz = m_z;
      if (per_we && m_imm == 1) m_act = per_data;
      else if (ldz) m_act = m_shd;
      if (per_we) m_shd = per_data;
      m_cnt = nxt; m_dir = ndir;
      if (ctl_we) begin
        m_mode = ctl_mode; m_coarse = ctl_coarse; m_fine = ctl_fine; m_imm = ctl_imm;
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (int'(cnt) != m_cnt || int'(dir_up) != m_dir) begin
      errors++;
      $display("FAIL %s cnt/dir act %0d/%0d exp %0d/%0d", req, cnt, dir_up, m_cnt, m_dir);
    end
    checks++;
    if (int'(zevt) != m_z || int'(pevt) != m_p) begin
      errors++;
      $display("FAIL R9 (%s) zero/prd strobes act %0d/%0d exp %0d/%0d", req, zevt, pevt, m_z, m_p);
    end
  end

  task automatic wr_ctl(input int mode, input int n, input int m, input int imm);
    ctl_we = 1'b1; ctl_mode = 2'(mode); ctl_coarse = 3'(n); ctl_fine = 3'(m); ctl_imm = 1'(imm);
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic wr_per(input int v);
    per_we = 1'b1; per_data = 16'(v);
    @(negedge clk);
    per_we = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired in %s act running exp finished", req);
    finish_run();
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    // R1: reset values
    checks++;
    if (cnt != 16'd0 || dir_up != 1'b1 || zevt || pevt) begin
      errors++;
      $display("FAIL R1 reset cnt/dir act %0d/%0d exp 0/1", cnt, dir_up);
    end
    idle(4);
    wr_ctl(3, 0, 0, 1);
    wr_per(4);
    req = "R2"; wr_ctl(0, 0, 0, 1); idle(14);
    req = "R5"; wr_ctl(3, 0, 0, 1); idle(6);
    wr_ctl(0, 0, 0, 1); idle(4);
    req = "R3"; wr_ctl(1, 0, 0, 1); idle(14);
    req = "R4"; wr_ctl(2, 0, 0, 1); idle(22);
    req = "R8"; wr_ctl(0, 0, 0, 1); idle(3); wr_per(2); idle(10);
    wr_per(5); idle(12);
    req = "R7"; wr_ctl(0, 0, 0, 0); idle(2); wr_per(7); idle(3);
    wr_per(3); idle(24);
    req = "R6"; wr_ctl(3, 0, 0, 1); wr_ctl(0, 2, 3, 1); idle(300);
    wr_ctl(3, 0, 0, 1); wr_ctl(2, 0, 1, 1); idle(40);
    wr_ctl(3, 0, 0, 1); wr_ctl(1, 3, 0, 1); idle(120);
    wr_ctl(3, 0, 0, 1); wr_ctl(0, 1, 7, 0); idle(200);
    finish_run();
  end
endmodule